// File: doc/BRIEF.md
# Asynchronous Bus Read Requester

This block is the device side of a single read over an unclocked, fully interlocked bus. The bus has one shared path that carries first the address and later the returned word, plus three handshake lines: a read request driven by the device, an acknowledge driven by the responder, and a data-ready strobe driven by the responder. A second acknowledge, driven by the device, confirms that the word was taken.

A local one-cycle start pulse with an address launches a read. The requester drives the address and raises its request. It releases both once it sees the responder's acknowledge. It then waits for the acknowledge to fall and for data-ready to rise. It captures the word and raises its own confirm. When data-ready falls it drops the confirm and pulses done with the captured word. Every line then rests low, so the next read can start at once.

The shared path is modelled as separate out, drive-enable and in signals. Both incoming handshake lines pass through a synchronizer chain before the state machine looks at them.

Top module: `async_read_requester`

## Requirements
- R1: When idle and not in reset, a start_i pulse makes rd_req_o and bus_oe_o high one clock later, with bus_out_o equal to the address presented with start.
- R2: rd_req_o, bus_oe_o and bus_out_o stay unchanged until the synchronized rsp_ack_i is seen high.
- R3: rd_req_o and bus_oe_o fall in the same cycle. The requester then waits for the synchronized rsp_ack_i to be low before it looks at rsp_valid_i.
- R4: When the synchronized rsp_valid_i is seen high, bus_in_i is captured and cfm_ack_o rises in the next cycle. The captured word appears on data_o.
- R5: cfm_ack_o holds until the synchronized rsp_valid_i is seen low. In the cycle it falls, done_o is high for exactly one cycle, busy_o is low, and data_o keeps the captured word afterwards.
- R6: bus_oe_o is low from the cycle rd_req_o falls until the next accepted start. While bus_oe_o is low, bus_out_o reads zero (default variant).
- R7: busy_o is high from the cycle after an accepted start until the done cycle. A start_i pulse while busy_o is high is ignored and launches no further request.
- R8: Each handshake input passes through SYNC_STAGES flops (default 2). A rsp_ack_i rise changes rd_req_o on the (SYNC_STAGES+1)-th rising clock edge after it.
- R9: During and right after reset, rd_req_o, bus_oe_o, cfm_ack_o, busy_o and done_o are low.
- R10: A start given in the done cycle itself is accepted, which gives back-to-back reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle read launch |
| addr_i | input | W | Address sampled with start_i |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | W | Last captured word |
| bus_out_o | output | W | Value driven onto the shared path |
| bus_oe_o | output | 1 | Drive enable for the shared path |
| bus_in_i | input | W | Value seen on the shared path |
| rd_req_o | output | 1 | Read request line |
| cfm_ack_o | output | 1 | Device confirm acknowledge |
| rsp_ack_i | input | 1 | Responder acknowledge |
| rsp_valid_i | input | 1 | Responder data-ready |

## Verification
A responder model in the bench replies with randomized delays. Outside its valid window it puts junk on the shared path, so a requester that captured too early or too late returns a wrong word. A start pulse during a transaction is injected; a design that did not ignore it would raise a second request or replace the address. The bench measures the ack-to-request latency, which exposes a missing or extra synchronizer stage. It also issues a start in the done cycle, which catches a design that stays busy one cycle too long. A monitor flags any cycle where the requester drives while the responder owns the path, as a design that released the drive late would.

// File: rtl/areq_pkg.sv
package areq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ADDR    = 3'd1,
      ST_RELEASE = 3'd2,
      ST_WAIT    = 3'd3,
      ST_CONFIRM = 3'd4
   } areq_state_e;
endpackage

// File: rtl/areq_sync.sv
module areq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("areq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/areq_fsm.sv
module areq_fsm
   import areq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ack_s,
   input  logic rdy_s,
   output logic load_addr,
   output logic cap_en,
   output logic req,
   output logic oe,
   output logic cfm,
   output logic busy,
   output logic done
);
   areq_state_e state, state_n;
   logic        done_q;

   always_comb begin
      state_n = state;
      unique case (state)
         ST_IDLE:    if (start)  state_n = ST_ADDR;
         ST_ADDR:    if (ack_s)  state_n = ST_RELEASE;
         ST_RELEASE: if (!ack_s) state_n = ST_WAIT;
         ST_WAIT:    if (rdy_s)  state_n = ST_CONFIRM;
         ST_CONFIRM: if (!rdy_s) state_n = ST_IDLE;
         default:                state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         done_q <= 1'b0;
      end else begin
         state  <= state_n;
         done_q <= (state == ST_CONFIRM) && !rdy_s;
      end
   end

   assign load_addr = (state == ST_IDLE) && start;
   assign cap_en    = (state == ST_WAIT) && rdy_s;
   assign req       = (state == ST_ADDR);
   assign oe        = (state == ST_ADDR);
   assign cfm       = (state == ST_CONFIRM);
   assign busy      = (state != ST_IDLE);
   assign done      = done_q;
endmodule

// File: rtl/areq_datapath.sv
module areq_datapath #(
   parameter int W            = 16,
   parameter bit ZERO_WHEN_OFF = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_addr,
   input  logic [W-1:0] addr,
   input  logic         cap_en,
   input  logic [W-1:0] bus_in,
   input  logic         oe,
   output logic [W-1:0] bus_out,
   output logic [W-1:0] word
);
   logic [W-1:0] addr_q;
   logic [W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         word_q <= '0;
      end else begin
         if (load_addr) addr_q <= addr;
         if (cap_en)    word_q <= bus_in;
      end
   end

   if (ZERO_WHEN_OFF) begin : g_gated_out
      assign bus_out = oe ? addr_q : '0;
   end else begin : g_raw_out
      logic unused_oe;
      assign unused_oe = oe;
      assign bus_out   = addr_q;
   end

   assign word = word_q;
endmodule

// File: rtl/async_read_requester.sv
module async_read_requester #(
   parameter int W             = 16,
   parameter int SYNC_STAGES   = 2,
   parameter bit ZERO_WHEN_OFF = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] addr_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] data_o,
   output logic [W-1:0] bus_out_o,
   output logic         bus_oe_o,
   input  logic [W-1:0] bus_in_i,
   output logic         rd_req_o,
   output logic         cfm_ack_o,
   input  logic         rsp_ack_i,
   input  logic         rsp_valid_i
);
   if (W < 1) begin : g_bad_width
      $error("async_read_requester: W must be positive");
   end

   logic ack_s, rdy_s, load_addr, cap_en, oe;

   areq_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
      .clk(clk), .rst_n(rst_n), .d(rsp_ack_i), .q(ack_s));

   areq_sync #(.STAGES(SYNC_STAGES)) u_sync_rdy (
      .clk(clk), .rst_n(rst_n), .d(rsp_valid_i), .q(rdy_s));

   areq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start_i), .ack_s(ack_s), .rdy_s(rdy_s),
      .load_addr(load_addr), .cap_en(cap_en), .req(rd_req_o), .oe(oe),
      .cfm(cfm_ack_o), .busy(busy_o), .done(done_o));

   areq_datapath #(.W(W), .ZERO_WHEN_OFF(ZERO_WHEN_OFF)) u_dp (
      .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .addr(addr_i),
      .cap_en(cap_en), .bus_in(bus_in_i), .oe(oe), .bus_out(bus_out_o),
      .word(data_o));

   assign bus_oe_o = oe;
endmodule

// File: rtl/areq_checker.sv
module areq_checker #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] bus_out_o,
   input logic         bus_oe_o,
   input logic         rd_req_o,
   input logic         cfm_ack_o,
   input logic         rsp_valid_i
);
   a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (rd_req_o && bus_oe_o));

   a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_req_o) && rd_req_o) |-> $stable(bus_out_o));

   a_r3_release_together: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_req_o) |-> !bus_oe_o);

   a_r4_confirm_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfm_ack_o) |-> $past(rsp_valid_i));

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r5_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!rd_req_o && !cfm_ack_o && !busy_o));

   a_r6_no_drive_in_confirm: assert property (@(posedge clk) disable iff (!rst_n)
      cfm_ack_o |-> !bus_oe_o);

   a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !done_o) |=> busy_o);
endmodule

bind async_read_requester areq_checker #(.W(W)) u_areq_checker (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
   .done_o(done_o), .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o),
   .rd_req_o(rd_req_o), .cfm_ack_o(cfm_ack_o), .rsp_valid_i(rsp_valid_i));

// File: tb/async_read_requester_bench.sv
module async_read_requester_bench;
   localparam int W    = 16;
   localparam int SYNC = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [W-1:0] addr_i = '0;
   logic         busy_o, done_o, bus_oe_o, rd_req_o, cfm_ack_o;
   logic [W-1:0] data_o, bus_out_o;
   logic [W-1:0] bus_in_i = '0;
   logic         rsp_ack_i = 1'b0;
   logic         rsp_valid_i = 1'b0;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   logic [W-1:0] seen_addr;
   int           ack_lat;
   int           req_rises = 0;
   int           oe_viol = 0;
   int           out_viol = 0;
   bit           rsp_driving = 0;
   logic         prev_req = 1'b0;

   always #5 clk = ~clk;

   async_read_requester #(.W(W), .SYNC_STAGES(SYNC)) u_async_read_requester (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
      .busy_o(busy_o), .done_o(done_o), .data_o(data_o),
      .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o), .bus_in_i(bus_in_i),
      .rd_req_o(rd_req_o), .cfm_ack_o(cfm_ack_o),
      .rsp_ack_i(rsp_ack_i), .rsp_valid_i(rsp_valid_i));

   function automatic logic [W-1:0] exp_data(input logic [W-1:0] a);
      return (a * 16'h9E37 + 16'h1234) ^ (a >> 3);
   endfunction

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rd_req_o && !prev_req) req_rises++;
      prev_req = rd_req_o;
      if (rsp_driving && bus_oe_o) oe_viol++;
      if (!bus_oe_o && bus_out_o != '0) out_viol++;
   end

   // Responder model
   initial begin
      forever begin
         @(negedge clk);
         if (rd_req_o) begin
            seen_addr = bus_out_o;
            repeat ($urandom_range(3, 0)) @(negedge clk);
            rsp_ack_i = 1'b1;
            ack_lat = 0;
            do begin @(negedge clk); ack_lat++; end while (rd_req_o);
            repeat ($urandom_range(3, 0)) @(negedge clk);
            rsp_ack_i = 1'b0;
            repeat ($urandom_range(4, 1)) @(negedge clk);
            rsp_driving = 1;
            bus_in_i    = exp_data(seen_addr);
            rsp_valid_i = 1'b1;
            while (!cfm_ack_o) @(negedge clk);
            repeat ($urandom_range(2, 0)) @(negedge clk);
            rsp_valid_i = 1'b0;
            rsp_driving = 0;
            bus_in_i    = W'($urandom);
            while (cfm_ack_o) @(negedge clk);
         end else begin
            bus_in_i = W'($urandom);
         end
      end
   end

   task automatic do_read(input logic [W-1:0] a, input bit poke, input bit b2b);
      int rr0, ov0, uv0, n;
      while (busy_o) @(negedge clk);
      rr0 = req_rises; ov0 = oe_viol; uv0 = out_viol;
      start_i = 1'b1; addr_i = a;
      @(negedge clk);
      start_i = 1'b0; addr_i = W'($urandom);
      check(rd_req_o && bus_oe_o && bus_out_o == a, "R1 launch", bus_out_o, a);
      if (poke) begin
         @(negedge clk);
         start_i = 1'b1; addr_i = ~a;
         @(negedge clk);
         start_i = 1'b0;
         check(busy_o == 1'b1, "R7 busy during ignored start", W'(busy_o), W'(1));
      end
      n = 0;
      while (!done_o && n < 500) begin @(negedge clk); n++; end
      check(done_o == 1'b1, "R5 done seen", W'(done_o), W'(1));
      check(data_o == exp_data(a), "R4 captured word", data_o, exp_data(a));
      check(seen_addr == a, "R2 address held to responder", seen_addr, a);
      check(ack_lat == SYNC + 1, "R8 sync latency", W'(ack_lat), W'(SYNC + 1));
      check(!busy_o && !cfm_ack_o && !rd_req_o, "R5 idle at done",
            W'({busy_o, cfm_ack_o, rd_req_o}), W'(0));
      check(req_rises == rr0 + 1, "R7 single request", W'(req_rises - rr0), W'(1));
      check(oe_viol == ov0 && out_viol == uv0, "R6 drive released",
            W'(oe_viol - ov0 + out_viol - uv0), W'(0));
      if (!b2b) begin
         @(negedge clk);
         check(!done_o && data_o == exp_data(a), "R5 done one cycle, word held",
               data_o, exp_data(a));
      end
   endtask

   initial begin
      logic [W-1:0] a;
      a = W'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      check(!rd_req_o && !bus_oe_o && !cfm_ack_o && !busy_o && !done_o,
            "R9 reset state", W'({rd_req_o, bus_oe_o, cfm_ack_o, busy_o, done_o}), W'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(!rd_req_o && !bus_oe_o && !busy_o, "R9 after reset",
            W'({rd_req_o, bus_oe_o, busy_o}), W'(0));
      do_read(16'h0000, 0, 0);
      do_read(16'hFFFF, 0, 0);
      do_read(16'h1234, 1, 0);
      do_read(16'hA5A5, 0, 1);
      do_read(16'h5A5A, 0, 1);   // R10 start in done cycle
      do_read(16'h0F0F, 1, 0);
      for (int i = 0; i < 40; i++) begin
         a = W'($urandom);
         do_read(a, ($urandom_range(3, 0) == 0), ($urandom_range(1, 0) == 1));
      end
      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         tests++; fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule